// File: doc/BRIEF.md
# Phantom Serial Clock Access Unit

This unit sits behind one byte-wide memory-mapped location and hides a bank of clock registers from ordinary accesses. Software unlocks the bank by writing a 64-bit recognition key one bit per write, on data bit 0. Once the whole key has been seen, the next 64 accesses move clock data serially, one bit per access, again on bit 0. Reads shift the stored time out. Writes shift a new time in.

The unit keeps a 64-bit BCD time image. The surrounding logic can overwrite this image through a load port and can watch it on a snapshot port. The serial stream holds eight bytes, lowest byte first, and each byte is sent least significant bit first:

- hundredths of a second
- seconds
- minutes
- hours (bit 7 selects 12-hour mode, bit 5 is PM in that mode, the digits sit in bits 4:0 or 5:0)
- day of week (low three bits)
- day of month (six bits)
- month (five bits)
- year

Top module: `phantom_clock_port`

## Requirements
- R1: After reset, `time_out` is zero, the unit is in key matching with its pointer at the first key bit, and `rdata` reads zero.
- R2: A cycle with `time_load` high copies `time_in` into the image, and `time_out` shows it on the next cycle.
- R3: Sixty-four consecutive writes whose bit 0 follows the key bytes 0xC5, 0x3A, 0xA3, 0x5C, 0xC5, 0x3A, 0xA3, 0x5C, each byte least significant bit first, enter the data phase. Key bit k is bit k mod 8 of byte k/8.
- R4: A read made during key matching returns the pointer to the first key bit.
- R5: A write during key matching whose bit 0 differs from the expected key bit returns the pointer to the first key bit. That bit is not counted as the first bit of a new key.
- R6: In the data phase, read number k (counting from 0) returns image bit k in `rdata[0]`. The image is the value captured when the last key bit was accepted, with the hundredths byte at bits 7:0 and the year at bits 63:56. Bits 7:1 of `rdata` are always zero.
- R7: A `time_load` during the data phase changes `time_out` but not the bits that the remaining reads return.
- R8: In a data phase that contains writes, write number k stores `wdata[0]` as image bit k. The image changes only once, and `time_out` shows the new value on the cycle after the 64th access.
- R9: A data phase made only of reads leaves the image unchanged. After the 64th access the unit is back in key matching, so a further read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Access strobe; one cycle high is one access |
| we | input | 1 | 1 = write access, 0 = read access |
| wdata | input | 8 | Write data; only bit 0 is used |
| rdata | output | 8 | Read data; bit 0 carries the data-phase bit, combinational |
| time_in | input | 64 | Time value for the load port |
| time_load | input | 1 | One-cycle strobe that loads `time_in` into the image |
| time_out | output | 64 | Current time image |

## Verification
The bench runs a clean key followed by 64 reads. This shows that the byte order and the bit order of both the key and the snapshot are right.

It then runs a key that is broken by a read, and another broken by a mismatching write placed where the wrong bit equals the first key bit. Each is followed by a full key. A pointer that is not cleared, or a bit that is wrongly reused, moves the phase boundary, and the expected read stream no longer lines up.

A load in the middle of a read phase tells the frozen snapshot apart from the live image. A 64-write phase, with the image checked after the 63rd and after the 64th write, confirms that the image is committed exactly once.

// File: rtl/phantom_clock_port.sv
module phantom_clock_port #(
  parameter int          DW  = 8,
  parameter int          W   = 64,
  parameter logic [63:0] KEY = 64'h5CA3_3AC5_5CA3_3AC5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [W-1:0]  time_in,
  input  logic          time_load,
  output logic [W-1:0]  time_out
);
  localparam int PW = $clog2(W);

  logic [W-1:0]  image, shr, shr_nxt;
  logic [PW-1:0] ptr;
  logic          in_data, wr_seen;

  wire rd   = cs & ~we;
  wire last = (ptr == PW'(W - 1));

  assign shr_nxt  = {(we ? wdata[0] : shr[0]), shr[W-1:1]};
  assign rdata    = {{(DW-1){1'b0}}, in_data & shr[0]};
  assign time_out = image;

  always_ff @(posedge clk) begin
    if (rst) begin
      image   <= '0;
      shr     <= '0;
      ptr     <= '0;
      in_data <= 1'b0;
      wr_seen <= 1'b0;
    end else begin
      if (time_load) image <= time_in;
      if (cs) begin
        if (!in_data) begin
          if (rd || (wdata[0] != KEY[ptr])) ptr <= '0;
          else if (last) begin
            in_data <= 1'b1;
            ptr     <= '0;
            shr     <= image;
            wr_seen <= 1'b0;
          end else ptr <= ptr + PW'(1);
        end else begin
          shr <= shr_nxt;
          if (we) wr_seen <= 1'b1;
          if (last) begin
            in_data <= 1'b0;
            ptr     <= '0;
            if (wr_seen || we) image <= shr_nxt;
          end else ptr <= ptr + PW'(1);
        end
      end
    end
  end

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (rd && !in_data) |=> (ptr == '0 && !in_data));

  assert_mismatch_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (cs && we && !in_data && wdata[0] != KEY[ptr]) |=> (ptr == '0 && !in_data));

  assert_enter_snapshot_R3: assert property (@(posedge clk) disable iff (rst)
    (cs && we && !in_data && last && wdata[0] == KEY[ptr]) |=> (in_data && shr == $past(image)));

  assert_exit_to_match_R9: assert property (@(posedge clk) disable iff (rst)
    (cs && in_data && last) |=> (!in_data && ptr == '0));

  assert_readonly_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    (cs && !we && in_data && last && !wr_seen && !time_load) |=> $stable(image));

  assert_single_commit_R8: assert property (@(posedge clk) disable iff (rst)
    (in_data && !(cs && last) && !time_load) |=> $stable(image));

  always_comb assert_upper_zero_R6: assert (rdata[DW-1:1] == '0);
endmodule

// File: tb/phantom_clock_port_test.sv
module phantom_clock_port_test;
  logic clk = 0, rst = 1, cs = 0, we = 0, time_load = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic [63:0] time_in = 0, time_out;
  int checks = 0, fails = 0;
  logic exp_q[$];
  string req_q[$];

  localparam logic [63:0] KEYV = {8'h5C, 8'hA3, 8'h3A, 8'hC5, 8'h5C, 8'hA3, 8'h3A, 8'hC5};
  localparam logic [63:0] T1 = 64'h99_12_07_31_05_92_35_17;
  localparam logic [63:0] T2 = 64'h24_06_15_02_23_45_59_42;
  localparam logic [63:0] T3 = 64'h70_01_01_01_A1_30_00_00;

  always #2.5 clk = ~clk;

  phantom_clock_port uut (.clk(clk), .rst(rst), .cs(cs), .we(we), .wdata(wdata),
    .rdata(rdata), .time_in(time_in), .time_load(time_load), .time_out(time_out));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cs && !we && exp_q.size() > 0) begin
      logic e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      chk(rdata == {7'b0, e}, r, {56'b0, rdata}, {63'b0, e});
    end
  end

  task automatic access(input bit w, input bit b);
    @(posedge clk); #1;
    cs = 1; we = w; wdata = {7'b1010101, b};
    @(posedge clk); #1;
    cs = 0; we = 0;
  endtask

  task automatic rd_exp(input bit e, input string r);
    exp_q.push_back(e);
    req_q.push_back(r);
    access(0, 0);
  endtask

  task automatic send_key(input int n);
    for (int i = 0; i < n; i++) access(1, KEYV[i]);
  endtask

  task automatic load(input logic [63:0] v);
    @(posedge clk); #1;
    time_in = v; time_load = 1;
    @(posedge clk); #1;
    time_load = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(time_out == 0, "R1 reset image", time_out, 0);
    rd_exp(0, "R1 reset rdata");

    load(T1);
    @(negedge clk);
    chk(time_out == T1, "R2 load", time_out, T1);

    send_key(64);
    for (int i = 0; i < 64; i++) rd_exp(T1[i], "R3/R6 snapshot stream");
    @(negedge clk);
    chk(time_out == T1, "R9 read-only keeps image", time_out, T1);
    rd_exp(0, "R9 back to matching");

    send_key(20);
    rd_exp(0, "R4 read in key");
    send_key(64);
    for (int i = 0; i < 64; i++) rd_exp(T1[i], "R4 restart after read");

    access(1, KEYV[0]);
    access(1, 1'b1);
    send_key(64);
    for (int i = 0; i < 64; i++) rd_exp(T1[i], "R5 mismatch restart");

    send_key(64);
    for (int i = 0; i < 30; i++) rd_exp(T1[i], "R7 before load");
    load(T2);
    for (int i = 30; i < 64; i++) rd_exp(T1[i], "R7 frozen snapshot");
    @(negedge clk);
    chk(time_out == T2, "R7 live image", time_out, T2);

    send_key(64);
    for (int i = 0; i < 63; i++) access(1, T3[i]);
    @(negedge clk);
    chk(time_out == T2, "R8 no early commit", time_out, T2);
    access(1, T3[63]);
    @(negedge clk);
    chk(time_out == T3, "R8 commit", time_out, T3);
    send_key(64);
    for (int i = 0; i < 64; i++) rd_exp(T3[i], "R8 readback");

    repeat (2) @(posedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule